// File: doc/BRIEF.md
# TLB Entry Array Access Port

This block holds the entry storage of a two-level translation buffer: a large unified buffer (64 entries by default) and a small instruction buffer (4 entries by default). Software reaches that storage through four memory-mapped arrays. Each array is a combination of buffer and half: the address half holds the page number, the ASID, the valid bit and the dirty bit, and the data half holds the physical page and the attribute flags. The array is chosen by a select input. The access address supplies the entry index and the mode bits, and the data word carries the packed fields.

Writes to the unified address array have two modes. The first is a direct indexed load. The second is an associative update: the written page number is compared against every valid entry of both buffers at once. In each buffer, only a single matching entry has its valid bit changed, and in the unified buffer its dirty bit as well. When either buffer holds more than one match, the block raises a multi-hit indication. A global invalidate input clears every valid bit in one cycle. The translation path that consumes these entries lives elsewhere.

Top module: `tlb_array_port`

## Requirements
- R1: After reset every entry field reads as zero, `req_ready` is high, and `rd_valid` and `multi_hit` are low.
- R2: A write to the unified address array (select 0, address bit 7 low) targets the entry indexed by address bits 13:8. It loads the page number from data bits 31:10, dirty from bit 9, valid from bit 8 and the ASID from bits 7:0. A read of that array returns the same packing.
- R3: A write to the unified data array (select 1, address bit 23 low) loads the physical page from data bits 28:10 and the nine flag bits from bits 8:0. The flag bits are: valid 8, size-high 7, user 6, writable 5, size-low 4, cacheable 3, dirty 2, shared 1, write-through 0. A read returns the page in bits 28:10 and the flags in bits 8:0, with bits 31:29 and 9 reading zero.
- R4: With address bit 23 high, a data-array access reaches a secondary 4-bit attribute field held in data bits 3:0. The other bits read zero, and the access leaves the primary page and flags untouched.
- R5: The instruction address array (select 2) is indexed by address bits 8:7. A write loads the page number from bits 31:10, valid from bit 8 and the ASID from bits 7:0. A read returns those fields, with bit 9 reading zero.
- R6: A write to the instruction data array (select 3) loads the physical page from bits 28:10. It keeps only the flag bits in mask 0x1DA and stores the others as zero.
- R7: An accepted read returns its word on `rd_data`, with `rd_valid` high, for exactly the one cycle after the request. An accepted write never raises `rd_valid`.
- R8: A write to the unified address array with address bit 7 high is associative. The key is the page number in data bits 31:10 together with `cur_asid`. An entry matches when it is valid, either shared or carrying an equal ASID, and equal in page number under its size mask. The size field {size-high, size-low} selects the compared bits: 00 compares all 22, 01 ignores the low 2, 10 ignores the low 6, and 11 ignores the low 10. When exactly one unified entry matches, its valid bit takes data bit 8 and its dirty bit takes data bit 9. When exactly one instruction entry matches, only its valid bit takes data bit 8.
- R9: An associative write changes no entry when nothing matches. An invalid entry, or an unshared entry whose ASID differs, never matches.
- R10: When more than one entry matches in either buffer, `multi_hit` goes high for the one cycle after the associative write. That buffer's entries are left unchanged.
- R11: While `inv_all` is high, `req_ready` is low. On the next edge every valid bit in both buffers is cleared, and all other fields keep their values.
- R12: The dirty and valid bits are shared state between the two halves of a unified entry. A unified data-array read shows what an address-array write stored in them, and the reverse holds as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Array: 0 unified address, 1 unified data, 2 instruction address, 3 instruction data |
| req_addr | input | 32 | Access address (index and mode bits) |
| req_wdata | input | 32 | Packed write data |
| cur_asid | input | 8 | ASID used as the associative-write key |
| inv_all | input | 1 | Invalidate every entry |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| multi_hit | output | 1 | Associative write found multiple matches |

## Verification
All storage updates, `rd_data`/`rd_valid` and `multi_hit` register on the clock edge that accepts the request, so each result is due one cycle after the request. `req_ready` follows `inv_all` within the same cycle. The bench drives a request on a falling edge, lets one rising edge accept it, and samples the outputs on the next falling edge. It checks state changes by reading the entry back with a later request. It also checks that `rd_valid` has dropped again one cycle later.

// File: rtl/tlbport_pkg.sv
package tlbport_pkg;

    localparam int VPN_W  = 22;
    localparam int ASID_W = 8;
    localparam int PPN_W  = 19;
    localparam int FLG_W  = 9;
    localparam int XA_W   = 4;

    // flag bit positions inside the 9-bit attribute field
    localparam int FB_VALID = 8;
    localparam int FB_SZHI  = 7;
    localparam int FB_SZLO  = 4;
    localparam int FB_DIRTY = 2;
    localparam int FB_SHARE = 1;

    localparam logic [FLG_W-1:0] INS_FLAG_KEEP = 9'h1DA;

    // address bits that steer an access
    localparam int ASSOC_BIT = 7;
    localparam int DATA2_BIT = 23;
    localparam int UIDX_LSB  = 8;
    localparam int IIDX_LSB  = 7;

    typedef enum logic [1:0] {
        SEL_UADDR = 2'd0,
        SEL_UDATA = 2'd1,
        SEL_IADDR = 2'd2,
        SEL_IDATA = 2'd3
    } arr_sel_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_UADDR_WR,
        OP_ASSOC_WR,
        OP_UDATA_WR,
        OP_UXA_WR,
        OP_IADDR_WR,
        OP_IDATA_WR
    } port_op_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [FLG_W-1:0]  flags;
        logic [XA_W-1:0]   xattr;
    } uni_ent_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [FLG_W-1:0]  flags;
    } ins_ent_t;

    typedef struct packed {
        logic        rd_valid;
        logic [31:0] rd_data;
        logic        multi_hit;
    } port_out_t;

    // Page-number compare mask chosen by the two size bits.
    function automatic logic [VPN_W-1:0] page_mask(input logic [FLG_W-1:0] f);
        logic [VPN_W-1:0] ones;
        ones = '1;
        case ({f[FB_SZHI], f[FB_SZLO]})
            2'b00:   page_mask = ones;
            2'b01:   page_mask = ones << 2;
            2'b10:   page_mask = ones << 6;
            default: page_mask = ones << 10;
        endcase
    endfunction

endpackage

// File: rtl/tlbport_decode.sv
module tlbport_decode
    import tlbport_pkg::*;
#(
    parameter int UIDX_W = 6,
    parameter int IIDX_W = 2
) (
    input  logic              acc,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [31:0]       addr,
    output port_op_e          op,
    output logic [UIDX_W-1:0] uidx,
    output logic [IIDX_W-1:0] iidx,
    output logic              data2
);
    logic assoc;

    assign uidx  = addr[UIDX_LSB +: UIDX_W];
    assign iidx  = addr[IIDX_LSB +: IIDX_W];
    assign data2 = addr[DATA2_BIT];
    assign assoc = addr[ASSOC_BIT];

    logic unused_addr;
    assign unused_addr = ^addr;

    always_comb begin
        op = OP_NONE;
        if (acc) begin
            if (!wr) begin
                op = OP_READ;
            end else begin
                case (arr_sel_e'(sel))
                    SEL_UADDR: op = assoc ? OP_ASSOC_WR : OP_UADDR_WR;
                    SEL_UDATA: op = data2 ? OP_UXA_WR : OP_UDATA_WR;
                    SEL_IADDR: op = OP_IADDR_WR;
                    default:   op = OP_IDATA_WR;
                endcase
            end
        end
    end
endmodule

// File: rtl/tlbport_cam.sv
module tlbport_cam
    import tlbport_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    input  logic [N-1:0]      ent_vld,
    input  logic [N-1:0]      ent_shr,
    input  logic [VPN_W-1:0]  ent_vpn  [N],
    input  logic [VPN_W-1:0]  ent_msk  [N],
    input  logic [ASID_W-1:0] ent_asid [N],
    output logic [N-1:0]      hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic asid_ok;
        logic vpn_ok;
        assign asid_ok = ent_shr[g] || (ent_asid[g] == key_asid);
        assign vpn_ok  = ((ent_vpn[g] ^ key_vpn) & ent_msk[g]) == '0;
        assign hit[g]  = ent_vld[g] && asid_ok && vpn_ok;
    end
endmodule

// File: rtl/tlbport_hitres.sv
module tlbport_hitres #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  hit,
    output logic [IW-1:0] idx,
    output logic          one,
    output logic          multi
);
    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                cnt = cnt + CW'(1);
                idx = IW'(i);
            end
        end
        one   = (cnt == CW'(1));
        multi = (cnt > CW'(1));
    end
endmodule

// File: rtl/tlb_array_port.sv
module tlb_array_port
    import tlbport_pkg::*;
#(
    parameter int UNI_N = 64,
    parameter int INS_N = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_sel,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [7:0]  cur_asid,
    input  logic        inv_all,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        multi_hit
);
    localparam int UIDX_W = $clog2(UNI_N);
    localparam int IIDX_W = $clog2(INS_N);

    uni_ent_t  uni_q [UNI_N];
    uni_ent_t  uni_d [UNI_N];
    ins_ent_t  ins_q [INS_N];
    ins_ent_t  ins_d [INS_N];
    port_out_t out_q, out_d;

    logic              acc;
    port_op_e          op;
    logic [UIDX_W-1:0] uidx;
    logic [IIDX_W-1:0] iidx;
    logic              data2;

    assign req_ready = !inv_all;
    assign acc       = req_valid && req_ready;

    tlbport_decode #(.UIDX_W(UIDX_W), .IIDX_W(IIDX_W)) u_dec (
        .acc  (acc),
        .wr   (req_write),
        .sel  (req_sel),
        .addr (req_addr),
        .op   (op),
        .uidx (uidx),
        .iidx (iidx),
        .data2(data2)
    );

    // per-entry compare inputs
    logic [UNI_N-1:0]  u_vld, u_shr, u_hit;
    logic [VPN_W-1:0]  u_vpn  [UNI_N];
    logic [VPN_W-1:0]  u_msk  [UNI_N];
    logic [ASID_W-1:0] u_asid [UNI_N];
    logic [INS_N-1:0]  i_vld, i_shr, i_hit;
    logic [VPN_W-1:0]  i_vpn  [INS_N];
    logic [VPN_W-1:0]  i_msk  [INS_N];
    logic [ASID_W-1:0] i_asid [INS_N];

    for (genvar g = 0; g < UNI_N; g++) begin : g_uflat
        assign u_vld[g]  = uni_q[g].flags[FB_VALID];
        assign u_shr[g]  = uni_q[g].flags[FB_SHARE];
        assign u_vpn[g]  = uni_q[g].vpn;
        assign u_msk[g]  = page_mask(uni_q[g].flags);
        assign u_asid[g] = uni_q[g].asid;
    end
    for (genvar g = 0; g < INS_N; g++) begin : g_iflat
        assign i_vld[g]  = ins_q[g].flags[FB_VALID];
        assign i_shr[g]  = ins_q[g].flags[FB_SHARE];
        assign i_vpn[g]  = ins_q[g].vpn;
        assign i_msk[g]  = page_mask(ins_q[g].flags);
        assign i_asid[g] = ins_q[g].asid;
    end

    tlbport_cam #(.N(UNI_N)) u_ucam (
        .key_vpn (req_wdata[31:10]),
        .key_asid(cur_asid),
        .ent_vld (u_vld),
        .ent_shr (u_shr),
        .ent_vpn (u_vpn),
        .ent_msk (u_msk),
        .ent_asid(u_asid),
        .hit     (u_hit)
    );

    tlbport_cam #(.N(INS_N)) u_icam (
        .key_vpn (req_wdata[31:10]),
        .key_asid(cur_asid),
        .ent_vld (i_vld),
        .ent_shr (i_shr),
        .ent_vpn (i_vpn),
        .ent_msk (i_msk),
        .ent_asid(i_asid),
        .hit     (i_hit)
    );

    logic [UIDX_W-1:0] u_idx;
    logic [IIDX_W-1:0] i_idx;
    logic              u_one, u_multi, i_one, i_multi;

    tlbport_hitres #(.N(UNI_N)) u_ures (
        .hit(u_hit), .idx(u_idx), .one(u_one), .multi(u_multi)
    );
    tlbport_hitres #(.N(INS_N)) u_ires (
        .hit(i_hit), .idx(i_idx), .one(i_one), .multi(i_multi)
    );

    // read word assembly
    logic [31:0] rd_word;
    always_comb begin
        rd_word = '0;
        case (arr_sel_e'(req_sel))
            SEL_UADDR: rd_word = {uni_q[uidx].vpn, uni_q[uidx].flags[FB_DIRTY],
                                  uni_q[uidx].flags[FB_VALID], uni_q[uidx].asid};
            SEL_UDATA: rd_word = data2 ? {28'd0, uni_q[uidx].xattr}
                                       : {3'd0, uni_q[uidx].ppn, 1'b0, uni_q[uidx].flags};
            SEL_IADDR: rd_word = {ins_q[iidx].vpn, 1'b0,
                                  ins_q[iidx].flags[FB_VALID], ins_q[iidx].asid};
            default:   rd_word = {3'd0, ins_q[iidx].ppn, 1'b0, ins_q[iidx].flags};
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^{req_wdata[31:29], u_one ^ u_multi};

    // next-state logic
    always_comb begin
        uni_d = uni_q;
        ins_d = ins_q;
        out_d = '{rd_valid: 1'b0, rd_data: out_q.rd_data, multi_hit: 1'b0};

        if (inv_all) begin
            for (int i = 0; i < UNI_N; i++) uni_d[i].flags[FB_VALID] = 1'b0;
            for (int i = 0; i < INS_N; i++) ins_d[i].flags[FB_VALID] = 1'b0;
        end

        case (op)
            OP_READ: begin
                out_d.rd_valid = 1'b1;
                out_d.rd_data  = rd_word;
            end
            OP_UADDR_WR: begin
                uni_d[uidx].vpn             = req_wdata[31:10];
                uni_d[uidx].asid            = req_wdata[7:0];
                uni_d[uidx].flags[FB_VALID] = req_wdata[8];
                uni_d[uidx].flags[FB_DIRTY] = req_wdata[9];
            end
            OP_ASSOC_WR: begin
                if (u_one) begin
                    uni_d[u_idx].flags[FB_VALID] = req_wdata[8];
                    uni_d[u_idx].flags[FB_DIRTY] = req_wdata[9];
                end
                if (i_one) begin
                    ins_d[i_idx].flags[FB_VALID] = req_wdata[8];
                end
                out_d.multi_hit = u_multi || i_multi;
            end
            OP_UDATA_WR: begin
                uni_d[uidx].ppn   = req_wdata[28:10];
                uni_d[uidx].flags = req_wdata[8:0];
            end
            OP_UXA_WR: begin
                uni_d[uidx].xattr = req_wdata[XA_W-1:0];
            end
            OP_IADDR_WR: begin
                ins_d[iidx].vpn             = req_wdata[31:10];
                ins_d[iidx].asid            = req_wdata[7:0];
                ins_d[iidx].flags[FB_VALID] = req_wdata[8];
            end
            OP_IDATA_WR: begin
                ins_d[iidx].ppn   = req_wdata[28:10];
                ins_d[iidx].flags = req_wdata[8:0] & INS_FLAG_KEEP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < UNI_N; i++) uni_q[i] <= '0;
            for (int i = 0; i < INS_N; i++) ins_q[i] <= '0;
            out_q <= '0;
        end else begin
            uni_q <= uni_d;
            ins_q <= ins_d;
            out_q <= out_d;
        end
    end

    assign rd_valid  = out_q.rd_valid;
    assign rd_data   = out_q.rd_data;
    assign multi_hit = out_q.multi_hit;

    // assertions
    AST_RD_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && req_ready && !req_write)); // R7
    AST_NO_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rd_valid); // R7
    AST_MH_FROM_ASSOC: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> $past(req_valid && req_ready && req_write &&
                            req_sel == 2'd0 && req_addr[ASSOC_BIT])); // R10
    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_all) |-> (u_vld == '0 && i_vld == '0)); // R11
    AST_INV_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_all) |-> !rd_valid); // R11

    for (genvar g = 0; g < INS_N; g++) begin : g_iflag_chk
        AST_INS_FLAGS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_q[g].flags & ~INS_FLAG_KEEP) == '0); // R6
    end
endmodule

// File: tb/tb_tlb_array_port.sv
module tb_tlb_array_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [1:0]  req_sel;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [7:0]  cur_asid;
    logic        inv_all;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        multi_hit;

    always #2 clk = ~clk;

    tlb_array_port dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_sel(req_sel), .req_addr(req_addr),
        .req_wdata(req_wdata), .cur_asid(cur_asid), .inv_all(inv_all),
        .rd_valid(rd_valid), .rd_data(rd_data), .multi_hit(multi_hit)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sel;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  asid;
        logic        rd;
        logic [31:0] exp;
        logic        mh;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 32'h0000_0300, 32'hABCD_E305, 8'h05, 1'b0, 32'h0,          1'b0, 4'd2},  // R2
        '{1'b0, 2'd0, 32'h0000_0300, 32'h0,         8'h05, 1'b1, 32'hABCD_E305, 1'b0, 4'd2},  // R2
        '{1'b0, 2'd1, 32'h0000_0300, 32'h0,         8'h05, 1'b1, 32'h0000_0104, 1'b0, 4'd12}, // R12
        '{1'b1, 2'd1, 32'h0000_0A00, 32'hF234_5FFF, 8'h05, 1'b0, 32'h0,          1'b0, 4'd3},  // R3
        '{1'b0, 2'd1, 32'h0000_0A00, 32'h0,         8'h05, 1'b1, 32'h1234_5DFF, 1'b0, 4'd3},  // R3
        '{1'b0, 2'd0, 32'h0000_0A00, 32'h0,         8'h05, 1'b1, 32'h0000_0300, 1'b0, 4'd12}, // R12
        '{1'b1, 2'd1, 32'h0080_0A00, 32'hFFFF_FFF7, 8'h05, 1'b0, 32'h0,          1'b0, 4'd4},  // R4
        '{1'b0, 2'd1, 32'h0080_0A00, 32'h0,         8'h05, 1'b1, 32'h0000_0007, 1'b0, 4'd4},  // R4
        '{1'b0, 2'd1, 32'h0000_0A00, 32'h0,         8'h05, 1'b1, 32'h1234_5DFF, 1'b0, 4'd4},  // R4
        '{1'b1, 2'd2, 32'h0000_0100, 32'h5555_5542, 8'h05, 1'b0, 32'h0,          1'b0, 4'd5},  // R5
        '{1'b0, 2'd2, 32'h0000_0100, 32'h0,         8'h05, 1'b1, 32'h5555_5542, 1'b0, 4'd5},  // R5
        '{1'b0, 2'd2, 32'h0000_0300, 32'h0,         8'h05, 1'b1, 32'h5555_5542, 1'b0, 4'd5},  // R5
        '{1'b0, 2'd2, 32'h0000_0180, 32'h0,         8'h05, 1'b1, 32'h0000_0000, 1'b0, 4'd5},  // R5
        '{1'b1, 2'd3, 32'h0000_0100, 32'h0ABC_DFFF, 8'h05, 1'b0, 32'h0,          1'b0, 4'd6},  // R6
        '{1'b0, 2'd3, 32'h0000_0100, 32'h0,         8'h05, 1'b1, 32'h0ABC_DDDA, 1'b0, 4'd6},  // R6
        '{1'b1, 2'd0, 32'h0000_1400, 32'h8000_0105, 8'h05, 1'b0, 32'h0,          1'b0, 4'd8},  // R8
        '{1'b1, 2'd0, 32'h0000_0080, 32'h8000_0200, 8'h05, 1'b0, 32'h0,          1'b0, 4'd8},  // R8
        '{1'b0, 2'd0, 32'h0000_1400, 32'h0,         8'h05, 1'b1, 32'h8000_0205, 1'b0, 4'd8},  // R8
        '{1'b1, 2'd0, 32'h0000_1500, 32'h9000_0105, 8'h05, 1'b0, 32'h0,          1'b0, 4'd9},  // R9
        '{1'b1, 2'd0, 32'h0000_0080, 32'h9000_0000, 8'h06, 1'b0, 32'h0,          1'b0, 4'd9},  // R9
        '{1'b0, 2'd0, 32'h0000_1500, 32'h0,         8'h05, 1'b1, 32'h9000_0105, 1'b0, 4'd9},  // R9
        '{1'b1, 2'd0, 32'h0000_0080, 32'h8000_0300, 8'h05, 1'b0, 32'h0,          1'b0, 4'd9},  // R9
        '{1'b0, 2'd0, 32'h0000_1400, 32'h0,         8'h05, 1'b1, 32'h8000_0205, 1'b0, 4'd9},  // R9
        '{1'b1, 2'd0, 32'h0000_0080, 32'h555F_FC00, 8'h05, 1'b0, 32'h0,          1'b0, 4'd8},  // R8
        '{1'b0, 2'd2, 32'h0000_0100, 32'h0,         8'h05, 1'b1, 32'h5555_5442, 1'b0, 4'd8},  // R8
        '{1'b0, 2'd1, 32'h0000_1400, 32'h0,         8'h05, 1'b1, 32'h0000_0004, 1'b0, 4'd8},  // R8
        '{1'b1, 2'd0, 32'h0000_1E00, 32'hC000_0105, 8'h05, 1'b0, 32'h0,          1'b0, 4'd10}, // R10
        '{1'b1, 2'd0, 32'h0000_1F00, 32'hC000_0105, 8'h05, 1'b0, 32'h0,          1'b0, 4'd10}, // R10
        '{1'b1, 2'd0, 32'h0000_0080, 32'hC000_0200, 8'h05, 1'b0, 32'h0,          1'b1, 4'd10}, // R10
        '{1'b0, 2'd0, 32'h0000_1E00, 32'h0,         8'h05, 1'b1, 32'hC000_0105, 1'b0, 4'd10}, // R10
        '{1'b0, 2'd0, 32'h0000_1F00, 32'h0,         8'h05, 1'b1, 32'hC000_0105, 1'b0, 4'd10}  // R10
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    // drive on a falling edge; outputs are sampled on the following falling edge
    task automatic do_req(input logic wr, input logic [1:0] sel, input logic [31:0] addr,
                          input logic [31:0] wdata, input logic [7:0] asid);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_sel   = sel;
        req_addr  = addr;
        req_wdata = wdata;
        cur_asid  = asid;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [31:0] addr,
                          input logic [31:0] exp, input string req);
        do_req(1'b0, sel, addr, 32'h0, 8'h05);
        check(rd_valid && rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog act=%08h exp=%08h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_sel = 2'd0;
        req_addr = '0; req_wdata = '0; cur_asid = 8'h05; inv_all = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(req_ready && !rd_valid && !multi_hit, "R1",
              {29'd0, req_ready, rd_valid, multi_hit}, 32'h4);
        rd_chk(2'd0, 32'h0000_0300, 32'h0, "R1");
        rd_chk(2'd3, 32'h0000_0000, 32'h0, "R1");

        // vector table
        for (int i = 0; i < NV; i++) begin
            automatic string tg = $sformatf("R%0d", VEC[i].tag);
            do_req(VEC[i].wr, VEC[i].sel, VEC[i].addr, VEC[i].wdata, VEC[i].asid);
            check(rd_valid == VEC[i].rd && (!VEC[i].rd || rd_data == VEC[i].exp)
                  && multi_hit == VEC[i].mh, tg,
                  VEC[i].rd ? rd_data : {30'd0, rd_valid, multi_hit},
                  VEC[i].rd ? VEC[i].exp : {30'd0, VEC[i].rd, VEC[i].mh});
        end

        // R7: read result lasts exactly one cycle
        do_req(1'b0, 2'd0, 32'h0000_0300, 32'h0, 8'h05);
        check(rd_valid, "R7", {31'd0, rd_valid}, 32'h1);
        @(negedge clk);
        check(!rd_valid, "R7", {31'd0, rd_valid}, 32'h0);

        // R11: invalidate; a read offered alongside is refused
        @(negedge clk);
        inv_all   = 1'b1;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_sel   = 2'd0;
        req_addr  = 32'h0000_0300;
        #1;
        check(!req_ready, "R11", {31'd0, req_ready}, 32'h0);
        @(negedge clk);
        inv_all   = 1'b0;
        req_valid = 1'b0;
        check(!rd_valid, "R7", {31'd0, rd_valid}, 32'h0);
        rd_chk(2'd0, 32'h0000_0300, 32'hABCD_E205, "R11");
        rd_chk(2'd3, 32'h0000_0100, 32'h0ABC_DCDA, "R11");
        rd_chk(2'd1, 32'h0000_0A00, 32'h1234_5CFF, "R11");
        rd_chk(2'd0, 32'h0000_1E00, 32'hC000_0005, "R11");
        do_req(1'b1, 2'd0, 32'h0000_0080, 32'hC000_0200, 8'h05);
        check(!multi_hit, "R11", {31'd0, multi_hit}, 32'h0);
        rd_chk(2'd0, 32'h0000_1F00, 32'hC000_0005, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule